// File: doc/BRIEF.md
# Locked Sequence Router and Checker

This block sits on the access path of a processor bus and follows atomic locked sequences as they pass through. Each access arrives with a lock flag, a read/write direction, the device that address decoding already picked, and two shadow-region attributes: shadowed and write-protected. The block chooses the device each access is actually steered to. It holds the bus locked for the length of a sequence, pulses when a sequence finishes cleanly, and marks accesses that break the lock rules.

A locked sequence is tied to the device its opening read targets. Shadow regions are the only exception. Inside a plain shadow region, locked reads are steered to the compatibility PCI bus and locked writes to the memory controller. If the opening read falls in a write-protected shadow region, the whole sequence goes to PCI. Outside shadow regions, a sequence that strays to another device is still passed through as decoded, but the access is flagged.

Accesses enter on a valid/ready stream and leave on a second valid/ready stream through one register stage. An input access is taken on a clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` is high only when the output register is empty or is being drained in the same cycle. An output beat stays stable until `rt_ready` accepts it. `bus_locked` and `seq_done` are plain status pins.

Top module: `lock_seq_router`

## Requirements
- R1: While no sequence is open, a locked read that is accepted opens a sequence. `bus_locked` goes high in the cycle after that acceptance.
- R2: A locked read followed by a locked write completes the sequence. In the cycle after the write is accepted, `seq_done` is high for exactly one cycle and `bus_locked` is low.
- R3: The four-access pattern is read, read, write, write. It completes the same way, with `seq_done` following only the second write, and `bus_locked` stays high in between.
- R4: While `bus_locked` is high, an access with `acc_lock` low is not accepted (`acc_ready` low), while locked accesses still are.
- R5: An in-sequence access outside any shadow region is routed to its decoded device. If that device differs from the opening read's device, `rt_viol` is 1 on that beat, and the routed device is unchanged.
- R6: In a shadow region that is not write-protected, locked reads route to `PCI_DEV` and locked writes route to `MEM_DEV`, with `rt_viol` 0.
- R7: When the opening read has both shadow attributes set, every access of that sequence routes to `PCI_DEV`, including writes and non-shadow accesses, with `rt_viol` 0.
- R8: An access that leaves both valid patterns ends the sequence. This means a read after two reads, or a read after read, read, write. That access is routed as decoded with `rt_viol` 1, `bus_locked` is low in the next cycle, and no `seq_done` pulse is produced.
- R9: A locked write with no open sequence is routed as decoded with `rt_viol` 1 and does not lock the bus.
- R10: An unlocked access while no sequence is open is routed to its decoded device with `rt_viol` 0, and `rt_write` echoes its direction.
- R11: While `rt_valid` is high and `rt_ready` is low, the output beat (`rt_dev`, `rt_write`, `rt_viol`) holds unchanged and `rt_valid` stays high.
- R12: After reset, `rt_valid`, `bus_locked` and `seq_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Input access present |
| acc_ready | output | 1 | Input access taken this cycle when valid is high |
| acc_lock | input | 1 | Access belongs to a locked sequence |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dev | input | DEV_W | Device chosen by address decoding |
| acc_shadow | input | 1 | Address lies in a shadow region |
| acc_wprot | input | 1 | Shadow region is write-protected |
| rt_valid | output | 1 | Routed beat present |
| rt_ready | input | 1 | Downstream takes the routed beat |
| rt_dev | output | DEV_W | Device the access is steered to |
| rt_write | output | 1 | Direction of the routed access |
| rt_viol | output | 1 | Access broke the lock rules |
| bus_locked | output | 1 | A locked sequence is open |
| seq_done | output | 1 | One-cycle pulse after a clean sequence end |

## Verification
The bench builds the block with `DEV_W` = 3, `MEM_DEV` = 0 and `PCI_DEV` = 1. Eight device codes leave room for the two fixed targets and several distinct ordinary devices. That makes cross-device strays, shadow redirection and write-protect redirection distinguishable on `rt_dev`. A stall pattern on `rt_ready` during part of the run reaches the hold behaviour of the output register while a sequence is still open.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  // Position inside a locked sequence
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,   // no lock open
    SQ_RD1  = 2'd1,   // one read seen
    SQ_RD2  = 2'd2,   // two reads seen
    SQ_WR1  = 2'd3    // read, read, write seen
  } seq_state_e;

endpackage

// File: rtl/lsr_seq_track.sv
module lsr_seq_track
  import lsr_pkg::*;
#(
  parameter int DEV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             lock_in,
  input  logic             write_in,
  input  logic [DEV_W-1:0] dev_in,
  input  logic             shadow_in,
  input  logic             wprot_in,
  output logic             open_o,
  output logic             start_o,
  output logic             bad_o,
  output logic             finish_o,
  output logic [DEV_W-1:0] anchor_dev_o,
  output logic             anchor_wp_o
);

  seq_state_e       st_q, st_d;
  logic [DEV_W-1:0] anchor_q;
  logic             wp_q;

  always_comb begin
    st_d     = st_q;
    start_o  = 1'b0;
    bad_o    = 1'b0;
    finish_o = 1'b0;
    if (take && lock_in) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (!write_in) begin
            st_d    = SQ_RD1;
            start_o = 1'b1;
          end else begin
            bad_o = 1'b1;
          end
        end
        SQ_RD1: begin
          if (write_in) begin
            st_d     = SQ_IDLE;
            finish_o = 1'b1;
          end else begin
            st_d = SQ_RD2;
          end
        end
        SQ_RD2: begin
          if (write_in) begin
            st_d = SQ_WR1;
          end else begin
            st_d  = SQ_IDLE;
            bad_o = 1'b1;
          end
        end
        SQ_WR1: begin
          st_d = SQ_IDLE;
          if (write_in) finish_o = 1'b1;
          else          bad_o    = 1'b1;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      anchor_q <= '0;
      wp_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_o) begin
        anchor_q <= dev_in;
        wp_q     <= shadow_in && wprot_in;
      end
    end
  end

  assign open_o       = (st_q != SQ_IDLE);
  assign anchor_dev_o = anchor_q;
  assign anchor_wp_o  = wp_q;

endmodule

// File: rtl/lsr_route.sv
module lsr_route #(
  parameter int DEV_W   = 3,
  parameter int MEM_DEV = 0,
  parameter int PCI_DEV = 1
) (
  input  logic             in_seq,
  input  logic             start,
  input  logic             bad,
  input  logic             write_in,
  input  logic [DEV_W-1:0] dev_in,
  input  logic             shadow_in,
  input  logic             wprot_in,
  input  logic [DEV_W-1:0] anchor_dev,
  input  logic             anchor_wp,
  output logic [DEV_W-1:0] dev_out,
  output logic             viol_out
);

  localparam logic [DEV_W-1:0] MEM_CODE = DEV_W'(MEM_DEV);
  localparam logic [DEV_W-1:0] PCI_CODE = DEV_W'(PCI_DEV);

  logic wp_eff;
  logic stray;

  assign wp_eff = start ? (shadow_in && wprot_in) : anchor_wp;
  assign stray  = in_seq && !start && !wp_eff && !shadow_in
                  && (dev_in != anchor_dev);

  always_comb begin
    dev_out  = dev_in;
    viol_out = 1'b0;
    if (bad) begin
      viol_out = 1'b1;
    end else if (in_seq) begin
      if (wp_eff) begin
        dev_out = PCI_CODE;
      end else if (shadow_in) begin
        dev_out = write_in ? MEM_CODE : PCI_CODE;
      end else begin
        viol_out = stray;
      end
    end
  end

endmodule

// File: rtl/lsr_out_reg.sv
module lsr_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data_in,
  output logic         slot_free,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  assign slot_free = !vld_q || ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (load) begin
        vld_q <= 1'b1;
        dat_q <= data_in;
      end else if (ready_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;

endmodule

// File: rtl/lock_seq_router.sv
module lock_seq_router #(
  parameter int DEV_W   = 3,
  parameter int MEM_DEV = 0,
  parameter int PCI_DEV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic             acc_lock,
  input  logic             acc_write,
  input  logic [DEV_W-1:0] acc_dev,
  input  logic             acc_shadow,
  input  logic             acc_wprot,
  output logic             rt_valid,
  input  logic             rt_ready,
  output logic [DEV_W-1:0] rt_dev,
  output logic             rt_write,
  output logic             rt_viol,
  output logic             bus_locked,
  output logic             seq_done
);

  localparam int BEAT_W = DEV_W + 2;

  logic             take;
  logic             slot_free;
  logic             seq_open;
  logic             seq_start, seq_bad, seq_finish;
  logic [DEV_W-1:0] anchor_dev;
  logic             anchor_wp;
  logic [DEV_W-1:0] route_dev;
  logic             route_viol;
  logic [BEAT_W-1:0] beat_in, beat_out;
  logic             done_q;

  assign acc_ready = slot_free && !(seq_open && !acc_lock);
  assign take      = acc_valid && acc_ready;

  lsr_seq_track #(.DEV_W(DEV_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .lock_in      (acc_lock),
    .write_in     (acc_write),
    .dev_in       (acc_dev),
    .shadow_in    (acc_shadow),
    .wprot_in     (acc_wprot),
    .open_o       (seq_open),
    .start_o      (seq_start),
    .bad_o        (seq_bad),
    .finish_o     (seq_finish),
    .anchor_dev_o (anchor_dev),
    .anchor_wp_o  (anchor_wp)
  );

  lsr_route #(.DEV_W(DEV_W), .MEM_DEV(MEM_DEV), .PCI_DEV(PCI_DEV)) u_route (
    .in_seq     (seq_open || seq_start),
    .start      (seq_start),
    .bad        (seq_bad),
    .write_in   (acc_write),
    .dev_in     (acc_dev),
    .shadow_in  (acc_shadow),
    .wprot_in   (acc_wprot),
    .anchor_dev (anchor_dev),
    .anchor_wp  (anchor_wp),
    .dev_out    (route_dev),
    .viol_out   (route_viol)
  );

  assign beat_in = {route_viol, acc_write, route_dev};

  lsr_out_reg #(.W(BEAT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .data_in   (beat_in),
    .slot_free (slot_free),
    .valid_o   (rt_valid),
    .ready_i   (rt_ready),
    .data_o    (beat_out)
  );

  assign rt_dev   = beat_out[DEV_W-1:0];
  assign rt_write = beat_out[DEV_W];
  assign rt_viol  = beat_out[DEV_W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= take && seq_finish;
  end

  assign bus_locked = seq_open;
  assign seq_done   = done_q;

endmodule

// File: rtl/lock_seq_router_chk.sv
module lock_seq_router_chk #(
  parameter int DEV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             acc_lock,
  input logic             acc_write,
  input logic             rt_valid,
  input logic             rt_ready,
  input logic [DEV_W-1:0] rt_dev,
  input logic             rt_write,
  input logic             rt_viol,
  input logic             bus_locked,
  input logic             seq_done
);

  p_lock_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_locked) |-> $past(acc_valid && acc_ready && acc_lock && !acc_write));

  p_done_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !bus_locked);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  p_block_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_locked && acc_valid && !acc_lock) |-> !acc_ready);

  p_hold_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && !rt_ready) |=>
      (rt_valid && $stable(rt_dev) && $stable(rt_write) && $stable(rt_viol)));

  p_ready_when_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_valid && !bus_locked) |-> acc_ready);

endmodule

bind lock_seq_router lock_seq_router_chk #(.DEV_W(DEV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_lock   (acc_lock),
  .acc_write  (acc_write),
  .rt_valid   (rt_valid),
  .rt_ready   (rt_ready),
  .rt_dev     (rt_dev),
  .rt_write   (rt_write),
  .rt_viol    (rt_viol),
  .bus_locked (bus_locked),
  .seq_done   (seq_done)
);

// File: tb/tb_lock_seq_router.sv
`timescale 1ns/1ps
module tb_lock_seq_router;

  localparam int DEV_W = 3;
  localparam int MEM   = 0;
  localparam int PCI   = 1;
  localparam int BW    = DEV_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_lock = 1'b0, acc_write = 1'b0;
  logic acc_shadow = 1'b0, acc_wprot = 1'b0;
  logic [DEV_W-1:0] acc_dev = '0;
  logic acc_ready, rt_valid, rt_write, rt_viol, bus_locked, seq_done;
  logic rt_ready = 1'b1;
  logic [DEV_W-1:0] rt_dev;

  int checks = 0, fails = 0;
  logic stall_en = 1'b0;
  logic [BW-1:0] expq[$];
  string tagq[$];

  always #5 clk = ~clk;

  lock_seq_router #(.DEV_W(DEV_W), .MEM_DEV(MEM), .PCI_DEV(PCI)) dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_lock(acc_lock),
    .acc_write(acc_write), .acc_dev(acc_dev), .acc_shadow(acc_shadow),
    .acc_wprot(acc_wprot), .rt_valid(rt_valid), .rt_ready(rt_ready),
    .rt_dev(rt_dev), .rt_write(rt_write), .rt_viol(rt_viol),
    .bus_locked(bus_locked), .seq_done(seq_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ready pattern changes just after each rising edge
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    #1 rt_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor: compares at falling edge, transfer happens at next rising edge
  logic          held = 1'b0;
  logic [BW-1:0] held_beat;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check("R11 valid held", int'(rt_valid), 1);
        check("R11 beat held", int'({rt_viol, rt_write, rt_dev}), int'(held_beat));
      end
      held      = rt_valid && !rt_ready;
      held_beat = {rt_viol, rt_write, rt_dev};
      if (rt_valid && rt_ready) begin
        if (expq.size() == 0) begin
          check("unexpected beat", 1, 0);
        end else begin
          logic [BW-1:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(t, int'({rt_viol, rt_write, rt_dev}), int'(e));
        end
      end
    end
  end

  task automatic send(input string req, input logic lk, input logic wr,
                      input int dev, input logic sh, input logic wp,
                      input int exp_dev, input logic exp_viol);
    expq.push_back({exp_viol, wr, DEV_W'(exp_dev)});
    tagq.push_back(req);
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_lock = lk; acc_write = wr;
    acc_dev = DEV_W'(dev); acc_shadow = sh; acc_wprot = wp;
    #1;
    do @(negedge clk); while (!acc_ready);
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  // status sample at the falling edge after the last accept
  task automatic status(input string req, input logic exp_lock, input logic exp_done);
    @(negedge clk);
    check({req, " bus_locked"}, int'(bus_locked), int'(exp_lock));
    check({req, " seq_done"}, int'(seq_done), int'(exp_done));
  endtask

  initial begin : watchdog
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R12 rt_valid", int'(rt_valid), 0);
    check("R12 bus_locked", int'(bus_locked), 0);
    check("R12 seq_done", int'(seq_done), 0);
    rst_n = 1'b1;

    // R10 unlocked pass-through
    send("R10 unlocked write", 0, 1, 5, 0, 0, 5, 0);
    send("R10 unlocked read", 0, 0, 3, 1, 0, 3, 0);
    status("R10", 0, 0);

    // R1 / R2 read-write
    send("R1 open read", 1, 0, 4, 0, 0, 4, 0);
    status("R1", 1, 0);
    send("R2 closing write", 1, 1, 4, 0, 0, 4, 0);
    status("R2", 0, 1);
    @(negedge clk);
    check("R2 done one cycle", int'(seq_done), 0);

    // R3 four-access pattern under output stalls (R11)
    stall_en = 1'b1;
    send("R3 read1", 1, 0, 2, 0, 0, 2, 0);
    send("R3 read2", 1, 0, 2, 0, 0, 2, 0);
    send("R3 write1", 1, 1, 2, 0, 0, 2, 0);
    status("R3 mid", 1, 0);
    send("R3 write2", 1, 1, 2, 0, 0, 2, 0);
    status("R3", 0, 1);
    stall_en = 1'b0;

    // R4 unlocked access blocked while locked
    send("R4 open read", 1, 0, 6, 0, 0, 6, 0);
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_lock = 1'b0; acc_write = 1'b1; acc_dev = 3'd5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4 blocked", int'(acc_ready), 0);
    end
    @(posedge clk); #1;
    acc_valid = 1'b0;
    send("R4 locked write accepted", 1, 1, 6, 0, 0, 6, 0);
    status("R4", 0, 1);

    // R5 cross-device stray flagged, routed as decoded
    send("R5 open read", 1, 0, 2, 0, 0, 2, 0);
    send("R5 stray read", 1, 0, 7, 0, 0, 7, 1);
    send("R5 same-dev write", 1, 1, 2, 0, 0, 2, 0);
    send("R5 stray write", 1, 1, 6, 0, 0, 6, 1);
    status("R5", 0, 1);

    // R6 shadow: reads to PCI, writes to memory
    send("R6 shadow read1", 1, 0, 3, 1, 0, PCI, 0);
    send("R6 shadow read2", 1, 0, 3, 1, 0, PCI, 0);
    send("R6 shadow write1", 1, 1, 3, 1, 0, MEM, 0);
    send("R6 shadow write2", 1, 1, 3, 1, 0, MEM, 0);
    status("R6", 0, 1);

    // R7 write-protected shadow: whole sequence to PCI
    send("R7 wp read1", 1, 0, 3, 1, 1, PCI, 0);
    send("R7 wp read2", 1, 0, 5, 0, 0, PCI, 0);
    send("R7 wp write1", 1, 1, 5, 0, 0, PCI, 0);
    send("R7 wp write2", 1, 1, 3, 1, 1, PCI, 0);
    status("R7", 0, 1);

    // R8 departure: read after two reads
    send("R8 read1", 1, 0, 4, 0, 0, 4, 0);
    send("R8 read2", 1, 0, 4, 0, 0, 4, 0);
    send("R8 third read", 1, 0, 4, 0, 0, 4, 1);
    status("R8 rrr", 0, 0);
    // R8 departure: read after read, read, write
    send("R8b read1", 1, 0, 5, 0, 0, 5, 0);
    send("R8b read2", 1, 0, 5, 0, 0, 5, 0);
    send("R8b write", 1, 1, 5, 0, 0, 5, 0);
    send("R8b read", 1, 0, 5, 0, 0, 5, 1);
    status("R8 rrwr", 0, 0);

    // R9 lone locked write
    send("R9 lone write", 1, 1, 2, 0, 0, 2, 1);
    status("R9", 0, 0);

    repeat (4) @(negedge clk);
    check("queue drained", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule